// File: doc/BRIEF.md
# Omega Multistage Packet Switch

This block moves packets from N sources to N sinks through log2(N) identical stages of two-by-two switching elements. In front of every stage the lanes pass through a perfect shuffle, which rotates the lane index left by one bit. Stage s then steers each packet by bit (log2(N)-1-s) of its destination field, so the most significant bit is used first. A 0 sends the packet to the upper output of its switch and a 1 sends it to the lower output. After the last stage, the lane index equals the destination, and each source-to-sink pair has exactly one path.

Each switch output has one register. An uncontended packet therefore takes log2(N) cycles from acceptance to delivery. If both inputs of a switch want the same output in the same cycle, a one-bit round-robin pointer in that switch picks the winner. The loser stays where it is and its ready signal stays low. Flow control is valid/ready at both edges of the block. A full register accepts a new packet in the same cycle in which its own packet moves on, so a flowing path carries one packet per cycle.

Top module: `omega_net`

## Requirements
- R1: While reset is held and on the first cycle after it, every bit of outValid is 0.
- R2: Every delivered packet leaves on the output lane whose index equals its destination field. outDest on that lane equals the lane index, and the payload is unchanged.
- R3: On an idle network with all outReady high, a packet accepted at clock edge e is valid at its output right after edge e+log2(N)-1. This is log2(N) cycles, and outValid is low before then.
- R4: Every accepted packet is delivered exactly once; none is lost or repeated.
- R5: Sources j and j+N/2 share first-stage switch j. When both are valid and their destination MSBs are equal, at most one of them sees inReady high in that cycle.
- R6: After reset, the first conflict at a switch is won by its upper input: at the first stage, that is the lower-numbered source of the pair. Each later conflict at that switch is won by the input that lost the previous conflict there.
- R7: While outValid is high and outReady is low on a lane, outValid stays high and outData stays unchanged on the next cycle.
- R8: inReady on a source is high only in a cycle in which that source's inValid is high and its packet is taken at the next edge.
- R9: On an idle network, the identity pattern (every source i sending to destination i at once) is accepted in full in a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | N | Per-source packet offered |
| inDest | input | N*log2(N) | Per-source destination index, source i in bits [i*log2(N) +: log2(N)] |
| inData | input | N*W | Per-source payload, source i in bits [i*W +: W] |
| inReady | output | N | Per-source: the offered packet is taken at the next edge |
| outValid | output | N | Per-sink packet present |
| outDest | output | N*log2(N) | Destination field of the packet on each sink lane |
| outData | output | N*W | Payload on each sink lane |
| outReady | input | N | Per-sink: the sink takes the presented packet at the next edge |

## Verification
A wrong shuffle rotation or a wrong stage-bit choice shows up log2(N) cycles after acceptance: outDest no longer equals the lane index, or the payload's tag does not match the port it was sent to. A broken ready chain or a bad pointer update shows up in the same cycle at inReady. Either two sources of a pair are both accepted in a conflict, or the acceptance order stops alternating. A stale valid bit shows up within a cycle of the sink handshake as a packet delivered twice, and a dropped load shows up at the end as a packet that never arrives.

// File: rtl/omega_pkg.sv
package omega_pkg;

  // Per-switch control strobes sent from control to datapath.
  typedef struct packed {
    logic loadUp;   // upper output register captures a packet
    logic loadLo;   // lower output register captures a packet
    logic srcUp;    // upper register source: 0 = input A, 1 = input B
    logic srcLo;    // lower register source: 0 = input A, 1 = input B
    logic drainUp;  // upper register hands its packet downstream
    logic drainLo;  // lower register hands its packet downstream
  } swStrobe_t;

  // Perfect shuffle: rotate a lane index of 'bits' bits left by one.
  function automatic int unsigned rotl(int unsigned v, int unsigned bits);
    int unsigned m;
    m = (32'd1 << bits) - 32'd1;
    return ((v << 1) | (v >> (bits - 1))) & m;
  endfunction

  // Inverse shuffle: rotate right by one.
  function automatic int unsigned rotr(int unsigned v, int unsigned bits);
    return (v >> 1) | ((v & 32'd1) << (bits - 1));
  endfunction

endpackage

// File: rtl/omega_ctrl.sv
module omega_ctrl
  import omega_pkg::*;
#(
  parameter int N  = 8,
  parameter int NB = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [N-1:0]    inValid,
  input  logic [NB-1:0]   inDest [N],
  input  logic [N-1:0]    regValid [NB],
  input  logic [NB-1:0]   regDest [NB][N],
  input  logic [N-1:0]    outReady,
  output swStrobe_t       strobe [NB][N/2],
  output logic [N-1:0]    inReady
);

  localparam int NSW = N / 2;

  logic [NSW-1:0] rrPick [NB];
  logic [NSW-1:0] rrFlip [NB];

  // Walk the stages from the sinks back to the sources so each stage
  // sees the drain decisions of the stage after it.
  always_comb begin
    logic [N-1:0]  popNext;
    logic [N-1:0]  popCur;
    logic [N-1:0]  laneReady;
    logic [N-1:0]  laneDrain;
    logic [N-1:0]  srcValid;
    logic [NB-1:0] srcDest [N];
    int            la;
    int            lb;
    int            sIdx;
    logic          va, vb, ba, bb, clash, gA, gB, pa, pb;

    popNext = '0;
    popCur  = '0;
    inReady = '0;
    for (int s = NB - 1; s >= 0; s--) begin
      sIdx = (s == 0) ? 0 : s - 1;
      for (int l = 0; l < N; l++) begin
        if (s == 0) begin
          srcValid[l] = inValid[l];
          srcDest[l]  = inDest[l];
        end else begin
          srcValid[l] = regValid[sIdx][l];
          srcDest[l]  = regDest[sIdx][l];
        end
        if (s == NB - 1) laneDrain[l] = regValid[s][l] && outReady[l];
        else             laneDrain[l] = popNext[rotl(l, NB)];
        laneReady[l] = !regValid[s][l] || laneDrain[l];
      end
      for (int j = 0; j < NSW; j++) begin
        la    = int'(rotr(2 * j, NB));
        lb    = int'(rotr(2 * j + 1, NB));
        va    = srcValid[la];
        vb    = srcValid[lb];
        ba    = srcDest[la][NB-1-s];
        bb    = srcDest[lb][NB-1-s];
        clash = va && vb && (ba == bb);
        gA    = va && (!clash || !rrPick[s][j]);
        gB    = vb && (!clash ||  rrPick[s][j]);
        pa    = gA && laneReady[2 * j + int'(ba)];
        pb    = gB && laneReady[2 * j + int'(bb)];
        popCur[2 * j]     = pa;
        popCur[2 * j + 1] = pb;
        strobe[s][j].loadUp  = (pa && !ba) || (pb && !bb);
        strobe[s][j].srcUp   = pb && !bb;
        strobe[s][j].loadLo  = (pa && ba) || (pb && bb);
        strobe[s][j].srcLo   = pb && bb;
        strobe[s][j].drainUp = laneDrain[2 * j];
        strobe[s][j].drainLo = laneDrain[2 * j + 1];
        rrFlip[s][j] = clash && (rrPick[s][j] ? pb : pa);
        if (s == 0) begin
          inReady[la] = pa;
          inReady[lb] = pb;
        end
      end
      popNext = popCur;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < NB; s++) rrPick[s] <= '0;
    end else begin
      for (int s = 0; s < NB; s++) rrPick[s] <= rrPick[s] ^ rrFlip[s];
    end
  end

endmodule

// File: rtl/omega_dp.sv
module omega_dp
  import omega_pkg::*;
#(
  parameter int N  = 8,
  parameter int W  = 16,
  parameter int NB = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [NB-1:0] inDest [N],
  input  logic [W-1:0]  inData [N],
  input  swStrobe_t     strobe [NB][N/2],
  output logic [N-1:0]  regValid [NB],
  output logic [NB-1:0] regDest [NB][N],
  output logic [W-1:0]  regData [NB][N]
);

  localparam int NSW = N / 2;

  for (genvar s = 0; s < NB; s++) begin : g_stage
    for (genvar j = 0; j < NSW; j++) begin : g_sw
      localparam int LA = int'(rotr(2 * j, NB));
      localparam int LB = int'(rotr(2 * j + 1, NB));

      logic [NB-1:0] dA, dB, dUp, dLo;
      logic [W-1:0]  xA, xB, xUp, xLo;
      logic          vUp, vLo;

      if (s == 0) begin : g_first
        assign dA = inDest[LA];
        assign dB = inDest[LB];
        assign xA = inData[LA];
        assign xB = inData[LB];
      end else begin : g_next
        assign dA = regDest[s-1][LA];
        assign dB = regDest[s-1][LB];
        assign xA = regData[s-1][LA];
        assign xB = regData[s-1][LB];
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          vUp <= 1'b0;
          vLo <= 1'b0;
        end else begin
          if (strobe[s][j].loadUp)       vUp <= 1'b1;
          else if (strobe[s][j].drainUp) vUp <= 1'b0;
          if (strobe[s][j].loadLo)       vLo <= 1'b1;
          else if (strobe[s][j].drainLo) vLo <= 1'b0;
        end
      end

      always_ff @(posedge clk) begin
        if (strobe[s][j].loadUp) begin
          dUp <= strobe[s][j].srcUp ? dB : dA;
          xUp <= strobe[s][j].srcUp ? xB : xA;
        end
        if (strobe[s][j].loadLo) begin
          dLo <= strobe[s][j].srcLo ? dB : dA;
          xLo <= strobe[s][j].srcLo ? xB : xA;
        end
      end

      assign regValid[s][2*j]   = vUp;
      assign regValid[s][2*j+1] = vLo;
      assign regDest[s][2*j]    = dUp;
      assign regDest[s][2*j+1]  = dLo;
      assign regData[s][2*j]    = xUp;
      assign regData[s][2*j+1]  = xLo;
    end
  end

endmodule

// File: rtl/omega_net.sv
module omega_net
  import omega_pkg::*;
#(
  parameter  int N  = 8,
  parameter  int W  = 16,
  localparam int NB = $clog2(N)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [N-1:0]    inValid,
  input  logic [N*NB-1:0] inDest,
  input  logic [N*W-1:0]  inData,
  output logic [N-1:0]    inReady,
  output logic [N-1:0]    outValid,
  output logic [N*NB-1:0] outDest,
  output logic [N*W-1:0]  outData,
  input  logic [N-1:0]    outReady
);

  logic [NB-1:0] inDestA [N];
  logic [W-1:0]  inDataA [N];
  logic [N-1:0]  regValid [NB];
  logic [NB-1:0] regDest [NB][N];
  logic [W-1:0]  regData [NB][N];
  swStrobe_t     strobe [NB][N/2];

  for (genvar l = 0; l < N; l++) begin : g_lane
    assign inDestA[l]            = inDest[l*NB +: NB];
    assign inDataA[l]            = inData[l*W +: W];
    assign outDest[l*NB +: NB]   = regDest[NB-1][l];
    assign outData[l*W +: W]     = regData[NB-1][l];
  end
  assign outValid = regValid[NB-1];

  omega_ctrl #(.N(N), .NB(NB)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inDest   (inDestA),
    .regValid (regValid),
    .regDest  (regDest),
    .outReady (outReady),
    .strobe   (strobe),
    .inReady  (inReady)
  );

  omega_dp #(.N(N), .W(W), .NB(NB)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .inDest   (inDestA),
    .inData   (inDataA),
    .strobe   (strobe),
    .regValid (regValid),
    .regDest  (regDest),
    .regData  (regData)
  );

endmodule

// File: rtl/omega_net_chk.sv
module omega_net_chk
  import omega_pkg::*;
#(
  parameter  int N  = 8,
  parameter  int W  = 16,
  localparam int NB = $clog2(N)
) (
  input logic            clk,
  input logic            rstN,
  input logic [N-1:0]    inValid,
  input logic [N*NB-1:0] inDest,
  input logic [N-1:0]    inReady,
  input logic [N-1:0]    outValid,
  input logic [N*NB-1:0] outDest,
  input logic [N*W-1:0]  outData,
  input logic [N-1:0]    outReady
);

  logic rstSeen;
  always_ff @(posedge clk) rstSeen <= !rstN;

  // R1: once a reset edge has passed, outputs stay idle while reset is held
  always @(posedge clk) begin
    if (!rstN && rstSeen) begin
      assert_idle_in_reset_R1: assert (outValid == '0);
    end
  end

  // R8: ready never raised toward a silent source
  assert_ready_needs_valid_R8: assert property (@(posedge clk) disable iff (!rstN)
    (inReady & ~inValid) == '0);

  for (genvar l = 0; l < N; l++) begin : g_out
    // R2: the packet on a lane carries that lane's index as destination
    assert_lane_matches_dest_R2: assert property (@(posedge clk) disable iff (!rstN)
      outValid[l] |-> (outDest[l*NB +: NB] == NB'(l)));

    // R7: a stalled output holds its packet
    assert_hold_when_stalled_R7: assert property (@(posedge clk) disable iff (!rstN)
      (outValid[l] && !outReady[l]) |=> (outValid[l] && $stable(outData[l*W +: W])));
  end

  for (genvar j = 0; j < N / 2; j++) begin : g_pair
    localparam int SA = j;
    localparam int SB = j + N / 2;
    // R5: a first-stage conflict admits at most one of the pair
    assert_single_winner_R5: assert property (@(posedge clk) disable iff (!rstN)
      (inValid[SA] && inValid[SB] &&
       inDest[SA*NB + NB - 1] == inDest[SB*NB + NB - 1])
      |-> !(inReady[SA] && inReady[SB]));
  end

endmodule

bind omega_net omega_net_chk #(.N(N), .W(W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inDest   (inDest),
  .inReady  (inReady),
  .outValid (outValid),
  .outDest  (outDest),
  .outData  (outData),
  .outReady (outReady)
);

// File: tb/omega_net_tb.sv
module omega_net_tb;

  localparam int N          = 8;
  localparam int W          = 16;
  localparam int NB         = $clog2(N);
  localparam int CLK_PERIOD = 10;
  localparam int HI         = N / 2;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [N-1:0]    inValid;
  logic [N*NB-1:0] inDest;
  logic [N*W-1:0]  inData;
  logic [N-1:0]    inReady;
  logic [N-1:0]    outValid;
  logic [N*NB-1:0] outDest;
  logic [N*W-1:0]  outData;
  logic [N-1:0]    outReady;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  omega_net #(.N(N), .W(W)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inDest(inDest), .inData(inData),
    .inReady(inReady), .outValid(outValid), .outDest(outDest), .outData(outData),
    .outReady(outReady)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic putPkt(int s, int d, int x);
    inValid[s]          = 1'b1;
    inDest[s*NB +: NB]  = NB'(d);
    inData[s*W +: W]    = W'(x);
  endtask

  function automatic int outD(int l);
    return int'(outData[l*W +: W]);
  endfunction

  function automatic int outDst(int l);
    return int'(outDest[l*NB +: NB]);
  endfunction

  // scoreboard for the random phase
  bit sentF [N][256];
  int sentD [N][256];
  bit rcvd  [N][256];
  int seqN  [N];
  int nSent = 0;
  int nRcvd = 0;

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R4 watchdog expired actual=%0d expected=%0d", nRcvd, nSent);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int order[$];
    int left0, left4, got1, got2;
    bit acc0, acc4;
    bit accepted [N];

    void'($urandom(32'd7051));
    inValid = '0; inDest = '0; inData = '0; outReady = '1;

    // reset
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(outValid == '0, "R1", "outValid in reset", int'(outValid), 0);
    check(inReady == '0, "R8", "inReady with no sources", int'(inReady), 0);
    @(posedge clk); #1 rstN = 1'b1;
    @(negedge clk);
    check(outValid == '0, "R1", "outValid after reset", int'(outValid), 0);

    // single packet latency: source 3 to sink 5
    @(posedge clk); #1 putPkt(3, 5, 16'hA5A5);
    @(negedge clk);
    check(inReady[3] == 1'b1, "R8", "inReady for lone packet", int'(inReady[3]), 1);
    @(posedge clk); #1 inValid[3] = 1'b0;
    for (int k = 1; k <= NB; k++) begin
      @(negedge clk);
      if (k < NB) begin
        check(outValid == '0, "R3", "early output", int'(outValid), 0);
      end else begin
        check(outValid == N'(1 << 5), "R3", "output after log2(N) cycles", int'(outValid), 1 << 5);
        check(outD(5) == 16'hA5A5, "R2", "payload on sink 5", outD(5), 16'hA5A5);
        check(outDst(5) == 5, "R2", "dest field on sink 5", outDst(5), 5);
      end
    end
    repeat (3) @(posedge clk);

    // identity pattern
    #1 for (int i = 0; i < N; i++) putPkt(i, i, 16'hB000 + i);
    @(negedge clk);
    check(inReady == '1, "R9", "identity accepted at once", int'(inReady), (1 << N) - 1);
    @(posedge clk); #1 inValid = '0;
    for (int k = 1; k <= NB; k++) begin
      @(negedge clk);
      if (k == NB) begin
        check(outValid == '1, "R9", "identity all delivered", int'(outValid), (1 << N) - 1);
        for (int i = 0; i < N; i++)
          check(outD(i) == 16'hB000 + i, "R2", "identity payload", outD(i), 16'hB000 + i);
      end
    end
    repeat (3) @(posedge clk);

    // conflict at first-stage switch 0: sources 0 and N/2, dest MSB both 0
    left0 = 3; left4 = 3; got1 = 0; got2 = 0;
    #1 putPkt(0, 1, 16'hD000); putPkt(HI, 2, 16'hD100);
    for (int c = 0; c < 14; c++) begin
      @(negedge clk);
      if (outValid[1] && outReady[1]) got1++;
      if (outValid[2] && outReady[2]) got2++;
      if (inValid[0] && inValid[HI])
        check(!(inReady[0] && inReady[HI]), "R5", "both of pair accepted",
              int'(inReady[0]) + int'(inReady[HI]), 1);
      acc0 = inValid[0] && inReady[0];
      acc4 = inValid[HI] && inReady[HI];
      if (acc0) order.push_back(0);
      if (acc4) order.push_back(HI);
      @(posedge clk); #1;
      if (acc0) begin
        left0--;
        if (left0 > 0) putPkt(0, 1, 16'hD000 + 3 - left0); else inValid[0] = 1'b0;
      end
      if (acc4) begin
        left4--;
        if (left4 > 0) putPkt(HI, 2, 16'hD100 + 3 - left4); else inValid[HI] = 1'b0;
      end
    end
    check(order.size() == 6, "R6", "conflict acceptances", order.size(), 6);
    for (int i = 0; i < order.size() && i < 6; i++)
      check(order[i] == ((i % 2 == 0) ? 0 : HI), "R6", "round-robin winner",
            order[i], (i % 2 == 0) ? 0 : HI);
    check(got1 == 3, "R4", "packets at sink 1", got1, 3);
    check(got2 == 3, "R4", "packets at sink 2", got2, 3);

    // output backpressure on sink 2
    @(posedge clk); #1 outReady = '0; putPkt(6, 2, 16'hC0DE);
    @(negedge clk);
    check(inReady[6] == 1'b1, "R8", "inReady source 6", int'(inReady[6]), 1);
    @(posedge clk); #1 inValid[6] = 1'b0;
    for (int k = 1; k <= NB + 4; k++) begin
      @(negedge clk);
      if (k >= NB) begin
        check(outValid[2] == 1'b1, "R7", "stalled valid held", int'(outValid[2]), 1);
        check(outD(2) == 16'hC0DE, "R7", "stalled data held", outD(2), 16'hC0DE);
      end
    end
    @(posedge clk); #1 outReady = '1;
    @(negedge clk);
    check(outValid[2] == 1'b1, "R7", "valid at release", int'(outValid[2]), 1);
    @(posedge clk);
    @(negedge clk);
    check(outValid[2] == 1'b0, "R4", "single delivery after release", int'(outValid[2]), 0);
    repeat (2) @(posedge clk);

    // random traffic: payload = {source, sequence}
    for (int s = 0; s < N; s++) seqN[s] = 0;
    for (int cyc = 0; cyc < 4200; cyc++) begin
      @(negedge clk);
      check((inReady & ~inValid) == '0, "R8", "ready without valid",
            int'(inReady & ~inValid), 0);
      for (int l = 0; l < N; l++) begin
        if (outValid[l] && outReady[l]) begin
          int x, s, q;
          bit ok;
          x = outD(l);
          s = x >> 8;
          q = x & 255;
          ok = (s < N) && sentF[s][q] && !rcvd[s][q] && (sentD[s][q] == l);
          check(ok, "R2", "delivery lane for tagged packet", l, (s < N) ? sentD[s][q] : -1);
          check(outDst(l) == l, "R2", "dest field", outDst(l), l);
          if (s < N) rcvd[s][q] = 1'b1;
          nRcvd++;
        end
      end
      for (int s = 0; s < N; s++) begin
        accepted[s] = inValid[s] && inReady[s];
        if (accepted[s]) begin
          int q;
          q = int'(inData[s*W +: W]) & 255;
          sentF[s][q] = 1'b1;
          sentD[s][q] = int'(inDest[s*NB +: NB]);
          nSent++;
        end
      end
      @(posedge clk); #1;
      for (int s = 0; s < N; s++) begin
        if (accepted[s]) inValid[s] = 1'b0;
        if (!inValid[s] && cyc < 3800 && seqN[s] < 256 && $urandom_range(99) < 40) begin
          putPkt(s, int'($urandom_range(N - 1)), (s << 8) | seqN[s]);
          seqN[s]++;
        end
      end
      for (int l = 0; l < N; l++)
        outReady[l] = (cyc >= 3800) || ($urandom_range(99) < 80);
    end
    check(nRcvd == nSent, "R4", "all accepted packets delivered", nRcvd, nSent);
    check(nSent > 100, "R4", "random traffic volume", nSent, 101);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule